// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This engine moves a block of words between one peripheral and system memory without processor involvement. Software programs a start address, a word total and a control word through a small slave port gated by a select line. Once started, each peripheral request makes the engine ask the processor for the shared bus. When the bus is handed over, the engine drives the memory address and a read or write strobe, and it acknowledges the peripheral in that same cycle so the peripheral can place or take the data word.

The two strobe lines are shared. While the processor owns the bus they carry register accesses into the engine. While the engine owns the bus it drives them toward memory. The engine can work in two ways. In cycle-steal mode it hands the bus back after every word. In burst mode it keeps the bus for as long as the peripheral keeps requesting. When the block is complete the engine releases the bus and raises an interrupt that stays up until software writes the control word again. The remaining word total can be read at any time to follow progress.

Top module: `dma_single_ch`

## Requirements
- R1: After reset, bus request, acknowledge and interrupt are low, and the address, count and control registers all read 0.
- R2: With select high and bus grant low, a write strobe loads the register chosen by the 2-bit register select: 0 selects the address, 1 the word count and 2 the control word. The control word has start at bit 0, direction at bit 1 (1 means peripheral to memory, using the write strobe) and burst at bit 2. A read strobe returns the selected register on the read data bus. The control readback adds busy at bit 3 and interrupt at bit 4.
- R3: Register writes are ignored while bus grant is high, even when select, register select and data are presented during a transfer.
- R4: When the engine is started and the peripheral requests, bus request rises. No strobe and no acknowledge appear until grant arrives. Each transfer cycle then shows the address register on the address bus, acknowledge high and exactly one strobe for one clock: write when direction is 1, read when it is 0.
- R5: After each word the address register rises by one and the count falls by one. The count read in the middle of a block gives the words still to move.
- R6: In cycle-steal mode exactly one word moves per bus grant, and bus request falls right after each word.
- R7: In burst mode, with the request held, words move in consecutive clocks under a single grant until the block is done.
- R8: In burst mode, if the request is low during a transfer cycle, bus request is dropped. It is raised again when the request returns, and the transfer resumes at the next address.
- R9: When the count reaches zero no further word moves even if the request stays high. Bus request falls, the interrupt rises, the count reads 0 and the start bit reads 0.
- R10: The interrupt stays high until the control register is written, whatever value is written. Register reads do not clear it.
- R11: Starting with a count of 0 raises the interrupt with no bus request and no memory strobe.
- R12: Writing the control word with start cleared while the engine waits for a request cancels the block. Later requests cause no bus request and no transfer, and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Engine select for register access |
| rsel_i | input | 2 | Register select |
| rd_io | inout | 1 | Read strobe: input from the processor when grant is low, memory read output when grant is high |
| wr_io | inout | 1 | Write strobe: input from the processor when grant is low, memory write output when grant is high |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Register read data |
| breq_o | output | 1 | Bus request to the processor |
| bgnt_i | input | 1 | Bus grant from the processor |
| addr_o | output | DATA_W | Memory address, driven while grant is high |
| dreq_i | input | 1 | Peripheral transfer request |
| dack_o | output | 1 | Peripheral acknowledge |
| irq_o | output | 1 | Block-complete interrupt |

## Verification
A register write attempt and a memory transfer can meet in the same cycle. The write strobe line is active because the engine is driving it toward memory. The bench provokes this by holding select, register select pointing at the count, and a foreign data value throughout a burst write. It then judges the result after the grant has dropped: the count must read 0, the address must have advanced by exactly the block length, and the control bits must be unchanged. A second overlap is the last word of a block with the request still held. The bench keeps the request high well past completion and confirms that no extra strobe appears and that bus request stays low.

// File: rtl/dma_sc_pkg.sv
// Package: shared encodings for the single-channel DMA engine.
// Assumes: register select is 2 bits wide; control fields sit in the low bits.
package dma_sc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_WAITG   = 3'd2,
        ST_XFER    = 3'd3,
        ST_RELEASE = 3'd4
    } seq_state_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTL_START = 0;
    localparam int CTL_DIR   = 1;
    localparam int CTL_BURST = 2;
    localparam int CTL_BUSY  = 3;
    localparam int CTL_IRQ   = 4;
    localparam int CTL_W     = 5;

endpackage

// File: rtl/dma_sc_pins.sv
// Module: strobe steering for the shared read/write lines.
// While grant is high the engine drives the lines toward memory; otherwise
// the lines are released and seen as processor strobes.
// Assumes: the processor tri-states its own drivers while it grants the bus.
module dma_sc_pins (
    input  logic bgnt_i,
    input  logic mem_rd_i,
    input  logic mem_wr_i,
    inout  wire  rd_io,
    inout  wire  wr_io,
    output logic cpu_rd_o,
    output logic cpu_wr_o
);

    // Drive the shared lines only while the bus belongs to the engine.
    assign rd_io = bgnt_i ? mem_rd_i : 1'bz;
    assign wr_io = bgnt_i ? mem_wr_i : 1'bz;

    // Processor strobes count only while the processor owns the bus.
    assign cpu_rd_o = !bgnt_i && (rd_io === 1'b1);
    assign cpu_wr_o = !bgnt_i && (wr_io === 1'b1);

endmodule

// File: rtl/dma_sc_regs.sv
// Module: programmable registers of the DMA engine (address, word count,
// control) plus the interrupt flag and the readback multiplexer.
// Assumes: processor strobes arrive already gated by bus grant; word_done
// and finish come from the sequencer and never coincide with a processor
// write, because writes are impossible while the engine holds the bus.
module dma_sc_regs
    import dma_sc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic [1:0]        rsel_i,
    input  logic              cpu_rd_i,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              word_done_i,
    input  logic              finish_i,
    input  logic              busy_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] count_o,
    output logic              start_o,
    output logic              dir_o,
    output logic              burst_o,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic wr_addr, wr_count, wr_ctrl;
    logic [CTL_W-1:0] ctrl_view;

    // Decode processor writes per register.
    assign wr_addr  = cs_i && cpu_wr_i && (rsel_i == SEL_ADDR);
    assign wr_count = cs_i && cpu_wr_i && (rsel_i == SEL_COUNT);
    assign wr_ctrl  = cs_i && cpu_wr_i && (rsel_i == SEL_CTRL);

    // Address register: loaded by software, stepped after each word.
    always_ff @(posedge clk) begin
        if (!rst_n)           addr_o <= '0;
        else if (wr_addr)     addr_o <= wdata_i;
        else if (word_done_i) addr_o <= addr_o + ONE;
    end

    // Word count register: loaded by software, reduced after each word.
    always_ff @(posedge clk) begin
        if (!rst_n)           count_o <= '0;
        else if (wr_count)    count_o <= wdata_i;
        else if (word_done_i) count_o <= count_o - ONE;
    end

    // Control fields: start clears itself when the block finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            dir_o   <= 1'b0;
            burst_o <= 1'b0;
        end else if (wr_ctrl) begin
            start_o <= wdata_i[CTL_START];
            dir_o   <= wdata_i[CTL_DIR];
            burst_o <= wdata_i[CTL_BURST];
        end else if (finish_i) begin
            start_o <= 1'b0;
        end
    end

    // Interrupt flag: set on completion, cleared by any control write.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_o <= 1'b0;
        else if (finish_i) irq_o <= 1'b1;
        else if (wr_ctrl)  irq_o <= 1'b0;
    end

    // Assemble the control readback view.
    always_comb begin
        ctrl_view            = '0;
        ctrl_view[CTL_START] = start_o;
        ctrl_view[CTL_DIR]   = dir_o;
        ctrl_view[CTL_BURST] = burst_o;
        ctrl_view[CTL_BUSY]  = busy_i;
        ctrl_view[CTL_IRQ]   = irq_o;
    end

    // Readback multiplexer, quiet unless a read is presented.
    always_comb begin
        rdata_o = '0;
        if (cs_i && cpu_rd_i) begin
            unique case (rsel_i)
                SEL_ADDR:  rdata_o = addr_o;
                SEL_COUNT: rdata_o = count_o;
                SEL_CTRL:  rdata_o = DATA_W'(ctrl_view);
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_sc_seq.sv
// Module: transfer sequencer. Waits for a peripheral request, asks for the
// bus, performs one-clock memory cycles while granted and decides after each
// word whether to continue, hand the bus back, or finish the block.
// Assumes: grant stays high while bus request is high, and falls only after
// bus request has fallen.
module dma_sc_seq
    import dma_sc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic              burst_i,
    input  logic [DATA_W-1:0] count_i,
    input  logic              dreq_i,
    input  logic              bgnt_i,
    output logic              breq_o,
    output logic              dack_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              word_done_o,
    output logic              finish_o,
    output logic              busy_o
);

    localparam logic [DATA_W-1:0] LAST = DATA_W'(1);

    seq_state_t st_q, st_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state and output decode.
    always_comb begin
        st_d        = st_q;
        breq_o      = 1'b0;
        dack_o      = 1'b0;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        word_done_o = 1'b0;
        finish_o    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_i == '0) finish_o = 1'b1;
                    else               st_d     = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!start_i)    st_d = ST_IDLE;
                else if (dreq_i) st_d = ST_WAITG;
            end
            ST_WAITG: begin
                breq_o = 1'b1;
                if (!start_i)    st_d = bgnt_i ? ST_RELEASE : ST_IDLE;
                else if (bgnt_i) st_d = ST_XFER;
            end
            ST_XFER: begin
                breq_o      = 1'b1;
                dack_o      = 1'b1;
                word_done_o = 1'b1;
                mem_wr_o    = dir_i;
                mem_rd_o    = !dir_i;
                if (count_i == LAST) begin
                    finish_o = 1'b1;
                    st_d     = ST_RELEASE;
                end else if (burst_i && dreq_i) begin
                    st_d = ST_XFER;
                end else begin
                    st_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!bgnt_i) st_d = start_i ? ST_ARMED : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Busy whenever a block is in flight.
    assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/dma_single_ch.sv
// Module: top of the single-channel DMA engine. Joins the strobe steering,
// the register file and the sequencer, and drives the memory address bus.
// Assumes: address, count and data share one width, DATA_W.
module dma_single_ch #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic [1:0]        rsel_i,
    inout  wire               rd_io,
    inout  wire               wr_io,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              breq_o,
    input  logic              bgnt_i,
    output logic [DATA_W-1:0] addr_o,
    input  logic              dreq_i,
    output logic              dack_o,
    output logic              irq_o
);

    logic              cpu_rd, cpu_wr;
    logic              mem_rd, mem_wr;
    logic              word_done, finish, busy;
    logic              start_q, dir_q, burst_q;
    logic [DATA_W-1:0] addr_q, count_q;

    dma_sc_pins u_pins (
        .bgnt_i   (bgnt_i),
        .mem_rd_i (mem_rd),
        .mem_wr_i (mem_wr),
        .rd_io    (rd_io),
        .wr_io    (wr_io),
        .cpu_rd_o (cpu_rd),
        .cpu_wr_o (cpu_wr)
    );

    dma_sc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs_i),
        .rsel_i      (rsel_i),
        .cpu_rd_i    (cpu_rd),
        .cpu_wr_i    (cpu_wr),
        .wdata_i     (wdata_i),
        .word_done_i (word_done),
        .finish_i    (finish),
        .busy_i      (busy),
        .rdata_o     (rdata_o),
        .addr_o      (addr_q),
        .count_o     (count_q),
        .start_o     (start_q),
        .dir_o       (dir_q),
        .burst_o     (burst_q),
        .irq_o       (irq_o)
    );

    dma_sc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_q),
        .dir_i       (dir_q),
        .burst_i     (burst_q),
        .count_i     (count_q),
        .dreq_i      (dreq_i),
        .bgnt_i      (bgnt_i),
        .breq_o      (breq_o),
        .dack_o      (dack_o),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .word_done_o (word_done),
        .finish_o    (finish),
        .busy_o      (busy)
    );

    // Present the address register only while the engine owns the bus.
    assign addr_o = bgnt_i ? addr_q : '0;

endmodule

// File: rtl/dma_single_ch_chk.sv
// Module: protocol checker for the DMA engine, bound into the top module.
// Assumes: synchronous active-low reset; all checks are off while in reset.
module dma_single_ch_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_i,
    input logic [1:0]        rsel_i,
    input logic              rd_io,
    input logic              wr_io,
    input logic              bgnt_i,
    input logic              breq_o,
    input logic              dack_o,
    input logic              irq_o,
    input logic [DATA_W-1:0] addr_q,
    input logic [DATA_W-1:0] count_q,
    input logic              word_done,
    input logic              dir_q,
    input logic              burst_q
);

    // Acknowledge to the peripheral only while the bus is granted.
    assert_ack_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> (bgnt_i && breq_o));

    // Never both memory strobes at once.
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bgnt_i |-> !(rd_io && wr_io));

    // Address steps up and count steps down by one per word.
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (addr_q == $past(addr_q) + DATA_W'(1)));
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (count_q == $past(count_q) - DATA_W'(1)));

    // Cycle-steal mode gives the bus back after every word.
    assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o && !burst_q) |=> !breq_o);

    // Last word raises the interrupt and drops the request.
    assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o && count_q == DATA_W'(1)) |=> (irq_o && !breq_o));

    // Interrupt holds until a control write by the processor.
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(cs_i && wr_io && !bgnt_i && rsel_i == 2'd2)) |=> irq_o);

    // Mode fields cannot change while the bus is granted.
    assert_no_write_in_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bgnt_i |=> ($stable(dir_q) && $stable(burst_q)));

endmodule

bind dma_single_ch dma_single_ch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs_i),
    .rsel_i    (rsel_i),
    .rd_io     (rd_io),
    .wr_io     (wr_io),
    .bgnt_i    (bgnt_i),
    .breq_o    (breq_o),
    .dack_o    (dack_o),
    .irq_o     (irq_o),
    .addr_q    (addr_q),
    .count_q   (count_q),
    .word_done (word_done),
    .dir_q     (dir_q),
    .burst_q   (burst_q)
);

// File: tb/dma_single_ch_tb.sv
// Bench: directed scenarios for the DMA engine, one task per scenario.
// The bench models the processor side: it grants the bus one half-clock
// after a request (unless held off) and drives the shared strobes only
// while the grant is low.
module dma_single_ch_tb;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0;
    logic [1:0]    rsel = 2'd0;
    logic          cpu_rd_drv = 1'b0;
    logic          cpu_wr_drv = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          breq;
    logic          bgnt = 1'b0;
    logic [DW-1:0] addr;
    logic          dreq = 1'b0;
    logic          dack;
    logic          irq;
    wire           rd_io;
    wire           wr_io;

    logic          hold_grant = 1'b0;
    int            n_checks = 0;
    int            n_err = 0;
    int            n_rd = 0, n_wr = 0, n_grant = 0, n_breq_rise = 0;
    int            run = 0, max_run = 0;
    logic [DW-1:0] exp_addr = '0;
    logic          bgnt_d = 1'b0, breq_d = 1'b0;
    bit            finished = 1'b0;

    always #2 clk = ~clk;

    assign rd_io = bgnt ? 1'bz : cpu_rd_drv;
    assign wr_io = bgnt ? 1'bz : cpu_wr_drv;

    dma_single_ch #(.DATA_W(DW)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .rsel_i  (rsel),
        .rd_io   (rd_io),
        .wr_io   (wr_io),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .breq_o  (breq),
        .bgnt_i  (bgnt),
        .addr_o  (addr),
        .dreq_i  (dreq),
        .dack_o  (dack),
        .irq_o   (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Processor-side arbiter model: grant follows request.
    always @(negedge clk) begin
        if (!rst_n) bgnt <= 1'b0;
        else        bgnt <= breq && !hold_grant;
    end

    // Memory-side monitor: counts strobes and grants, checks addresses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bgnt && !bgnt_d) n_grant++;
            if (breq && !breq_d) n_breq_rise++;
            if (bgnt && (rd_io === 1'b1 || wr_io === 1'b1)) begin
                if (rd_io === 1'b1) n_rd++;
                if (wr_io === 1'b1) n_wr++;
                if (dack !== 1'b1) chk("R4 ack with strobe", 32'(dack), 32'd1);
                if (addr !== exp_addr) chk("R5 address sequence", 32'(addr), 32'(exp_addr));
                exp_addr = exp_addr + 1'b1;
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
                if (dack === 1'b1) chk("R4 ack without strobe", 32'(dack), 32'd0);
            end
        end
        bgnt_d = bgnt;
        breq_d = breq;
    end

    task automatic clear_stats(input logic [DW-1:0] base);
        n_rd = 0; n_wr = 0; n_grant = 0; n_breq_rise = 0;
        run = 0; max_run = 0; exp_addr = base;
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [DW-1:0] val);
        @(negedge clk); #1;
        cs = 1'b1; rsel = sel; wdata = val; cpu_wr_drv = 1'b1;
        @(negedge clk); #1;
        cs = 1'b0; cpu_wr_drv = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [DW-1:0] val);
        @(negedge clk); #1;
        cs = 1'b1; rsel = sel; cpu_rd_drv = 1'b1;
        #1;
        val = rdata;
        cs = 1'b0; cpu_rd_drv = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int i;
        for (i = 0; i < 2000 && irq !== 1'b1; i++) begin
            @(negedge clk); #1;
        end
        chk(tag, 32'(irq), 32'd1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 breq after reset", 32'(breq), 32'd0);
        chk("R1 dack after reset", 32'(dack), 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        cpu_read(2'd0, v); chk("R1 addr reset", 32'(v), 32'd0);
        cpu_read(2'd1, v); chk("R1 count reset", 32'(v), 32'd0);
        cpu_read(2'd2, v); chk("R1 ctrl reset", 32'(v), 32'd0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] v;
        cpu_write(2'd0, 16'hABCD);
        cpu_write(2'd1, 16'h0012);
        cpu_write(2'd2, 16'h0006);
        cpu_read(2'd0, v); chk("R2 addr readback", 32'(v), 32'hABCD);
        cpu_read(2'd1, v); chk("R2 count readback", 32'(v), 32'h0012);
        cpu_read(2'd2, v); chk("R2 ctrl readback", 32'(v), 32'h0006);
        cpu_read(2'd3, v); chk("R2 unused select", 32'(v), 32'h0);
    endtask

    task automatic t_steal();
        logic [DW-1:0] v;
        hold_grant = 1'b1;
        clear_stats(16'h0100);
        cpu_write(2'd0, 16'h0100);
        cpu_write(2'd1, 16'd3);
        dreq = 1'b1;
        cpu_write(2'd2, 16'h0003);
        repeat (6) @(negedge clk);
        #1;
        chk("R4 breq while waiting for grant", 32'(breq), 32'd1);
        chk("R4 no strobe before grant", 32'(n_wr + n_rd), 32'd0);
        hold_grant = 1'b0;
        wait_irq("R9 irq after steal block");
        repeat (10) @(negedge clk);
        #1;
        chk("R6 words in steal mode", 32'(n_wr), 32'd3);
        chk("R4 no read strobe for write direction", 32'(n_rd), 32'd0);
        chk("R6 one grant per word", 32'(n_grant), 32'd3);
        chk("R6 no back-to-back words", 32'(max_run), 32'd1);
        chk("R9 breq low after block", 32'(breq), 32'd0);
        dreq = 1'b0;
        cpu_read(2'd1, v); chk("R9 count reads zero", 32'(v), 32'd0);
        cpu_read(2'd0, v); chk("R5 address after block", 32'(v), 32'h0103);
        cpu_read(2'd2, v); chk("R9 start cleared, irq set", 32'(v), 32'h0012);
    endtask

    task automatic t_irq_hold();
        logic [DW-1:0] v;
        repeat (20) @(negedge clk);
        #1;
        chk("R10 irq held", 32'(irq), 32'd1);
        cpu_read(2'd2, v);
        chk("R10 irq survives read", 32'(irq), 32'd1);
        cpu_write(2'd2, 16'h0000);
        chk("R10 irq cleared by control write", 32'(irq), 32'd0);
    endtask

    task automatic t_burst();
        clear_stats(16'h0020);
        cpu_write(2'd0, 16'h0020);
        cpu_write(2'd1, 16'd4);
        dreq = 1'b1;
        cpu_write(2'd2, 16'h0005);
        wait_irq("R9 irq after burst");
        repeat (8) @(negedge clk);
        #1;
        dreq = 1'b0;
        chk("R7 burst words", 32'(n_rd), 32'd4);
        chk("R4 no write strobe for read direction", 32'(n_wr), 32'd0);
        chk("R7 single grant", 32'(n_grant), 32'd1);
        chk("R7 consecutive words", 32'(max_run), 32'd4);
    endtask

    task automatic t_burst_gap();
        logic [DW-1:0] v;
        int i;
        clear_stats(16'h0040);
        cpu_write(2'd0, 16'h0040);
        cpu_write(2'd1, 16'd5);
        dreq = 1'b1;
        cpu_write(2'd2, 16'h0005);
        for (i = 0; i < 200 && n_rd < 2; i++) begin
            @(negedge clk); #1;
        end
        dreq = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R8 breq dropped in gap", 32'(breq), 32'd0);
        chk("R8 words before gap", 32'(n_rd), 32'd2);
        cpu_read(2'd1, v); chk("R5 progress count", 32'(v), 32'd3);
        cpu_read(2'd0, v); chk("R5 progress address", 32'(v), 32'h0042);
        dreq = 1'b1;
        wait_irq("R8 irq after resumed burst");
        dreq = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R8 total words", 32'(n_rd), 32'd5);
        chk("R8 two grants", 32'(n_grant), 32'd2);
        chk("R8 request raised again", 32'(n_breq_rise), 32'd2);
        cpu_read(2'd0, v); chk("R8 final address", 32'(v), 32'h0045);
    endtask

    task automatic t_ignore_in_grant();
        logic [DW-1:0] v;
        int i;
        clear_stats(16'h0300);
        cpu_write(2'd0, 16'h0300);
        cpu_write(2'd1, 16'd3);
        cpu_write(2'd2, 16'h0007);
        dreq = 1'b1;
        for (i = 0; i < 100 && bgnt !== 1'b1; i++) begin
            @(negedge clk); #1;
        end
        cs = 1'b1; rsel = 2'd1; wdata = 16'h0077; cpu_wr_drv = 1'b1;
        for (i = 0; i < 100 && bgnt === 1'b1; i++) begin
            @(negedge clk); #1;
        end
        cs = 1'b0; cpu_wr_drv = 1'b0;
        dreq = 1'b0;
        wait_irq("R9 irq after burst write");
        chk("R3 words moved", 32'(n_wr), 32'd3);
        cpu_read(2'd1, v); chk("R3 count unchanged by write in grant", 32'(v), 32'd0);
        cpu_read(2'd0, v); chk("R3 address advanced by block only", 32'(v), 32'h0303);
        cpu_read(2'd2, v); chk("R3 control bits intact", 32'(v), 32'h0016);
    endtask

    task automatic t_zero_count();
        logic [DW-1:0] v;
        clear_stats(16'h0000);
        cpu_write(2'd1, 16'd0);
        dreq = 1'b1;
        cpu_write(2'd2, 16'h0001);
        repeat (2) @(negedge clk);
        #1;
        chk("R11 irq on zero count", 32'(irq), 32'd1);
        repeat (6) @(negedge clk);
        #1;
        dreq = 1'b0;
        chk("R11 no bus request", 32'(n_breq_rise), 32'd0);
        chk("R11 no strobe", 32'(n_rd + n_wr), 32'd0);
        cpu_read(2'd2, v); chk("R11 start cleared", 32'(v), 32'h0010);
    endtask

    task automatic t_abort();
        logic [DW-1:0] v;
        clear_stats(16'h0500);
        dreq = 1'b0;
        cpu_write(2'd0, 16'h0500);
        cpu_write(2'd1, 16'd4);
        cpu_write(2'd2, 16'h0001);
        repeat (3) @(negedge clk);
        cpu_write(2'd2, 16'h0000);
        dreq = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        chk("R12 no bus request after cancel", 32'(n_breq_rise), 32'd0);
        chk("R12 no strobe after cancel", 32'(n_rd + n_wr), 32'd0);
        dreq = 1'b0;
        cpu_read(2'd2, v); chk("R12 not busy", 32'(v), 32'h0000);
        cpu_read(2'd1, v); chk("R12 count untouched", 32'(v), 32'd4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_regs();
        t_steal();
        t_irq_hold();
        t_burst();
        t_burst_gap();
        t_ignore_in_grant();
        t_zero_count();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule